// File: doc/BRIEF.md
# Frame Readout Status Monitor

This block follows a continuous frame readout from the side of the host. It keeps a 9-bit status word. Some bits of that word mirror the phase that the frame reformatter reports: waiting for a header, buffer address valid, waiting for a buffer address, and frame transfer in progress. The other bits record events: a bad end of frame, a FIFO that has gone quiet, an expired half-full wait, and an abort that arrives while a frame is being read.

The block raises a one-cycle frame interrupt in two cases: when a frame completes, and when an error or abort occurs. In the same cycle it presents a fresh snapshot of the event bits. Errors are only reported. Nothing in the block halts the readout, and the FIFO watchdog re-arms by itself, so reading carries on until the abort command ends it upstream.

The FIFO inactivity limit and the half-full wait limit are set in microseconds, together with the clock rate in MHz. The default for both limits is 65 ms.

Top module: `rdo_status_mon`

## Requirements
- R1: While reset is asserted, the status word is 0 and the interrupt is low.
- R2: The phase bits follow their inputs one clock later: bit 0 follows header wait, bit 2 follows buffer address valid, bit 6 follows frame reading, and bit 7 follows buffer address wait.
- R3: A frame-done pulse gives an interrupt one clock later. If no event occurs in that cycle, event bits 1, 3, 4, 5 and 8 all read 0 alongside the interrupt.
- R4: An end-of-frame error pulse gives an interrupt one clock later, with bit 1 set.
- R5: If frame reading stays high for LIMIT consecutive clocks with no FIFO read strobe (LIMIT = FIFO_TO_US × CLK_MHZ), an interrupt follows the LIMIT-th clock, with bits 5 and 3 set. No interrupt comes earlier.
- R6: A FIFO read strobe restarts the inactivity count, so strobes spaced closer than LIMIT clocks never cause a time-out.
- R7: No inactivity time-out occurs while frame reading is low, however long that lasts.
- R8: If the half-full wait stays high for HF_TO_US × CLK_MHZ consecutive clocks, an interrupt follows, with bit 8 set and bit 3 left clear.
- R9: An abort pulse while frame reading is high gives an interrupt with bits 4 and 3 set. An abort while frame reading is low is ignored: there is no interrupt and the status word is unchanged.
- R10: Event bits keep the value captured at the last interrupt until the next interrupt re-captures them.
- R11: A time-out does not stop the monitoring. If frame reading stays high with no strobe, a further time-out interrupt comes every LIMIT clocks.
- R12: Events in the same clock merge into a single interrupt whose word carries all of their bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdr_wait_i | input | 1 | Reformatter is waiting for a frame header |
| fba_valid_i | input | 1 | Frame buffer address is valid |
| frame_rd_i | input | 1 | Frame transfer is in progress |
| fba_wait_i | input | 1 | Waiting for a frame buffer address |
| eof_err_i | input | 1 | One-cycle pulse: end-of-frame error |
| frame_done_i | input | 1 | One-cycle pulse: frame complete |
| fifo_rd_i | input | 1 | One-cycle pulse per FIFO word read |
| hf_wait_i | input | 1 | Waiting for the FIFO to reach half full |
| abort_i | input | 1 | One-cycle pulse: abort command |
| stat_word_o | output | 9 | Status word: phase bits live, event bits from the last interrupt |
| frame_irq_o | output | 1 | One-cycle frame interrupt |

## Verification
The watchdog is tried with three patterns. In the first, frame reading is held with no strobes, which fixes the exact expiry clock and shows that the count re-arms. In the second, strobes come just inside the limit, which separates a reload from a counter that keeps running. In the third, frame reading is held low for a long time, which shows that the count is gated. Aborts are sent both inside and outside a frame transfer, which tells qualified aborts from ignored ones. Events are also applied one at a time and in coincident pairs, which separates correct merging from a lost or doubled interrupt. The event bits are sampled between interrupts to show they hold.

// File: rtl/rdo_status_pkg.sv
package rdo_status_pkg;
  localparam int STAT_W = 9;

  // status word bit positions
  localparam int B_HDR_WAIT  = 0;
  localparam int B_EOF_ERR   = 1;
  localparam int B_FBA_VALID = 2;
  localparam int B_LAST      = 3;
  localparam int B_ABORT     = 4;
  localparam int B_FIFO_TO   = 5;
  localparam int B_FRAME_RD  = 6;
  localparam int B_FBA_WAIT  = 7;
  localparam int B_HF_TO     = 8;

  localparam logic [STAT_W-1:0] PHASE_MASK = 9'h0C5;
  localparam logic [STAT_W-1:0] EVENT_MASK = 9'h13A;

  typedef logic [STAT_W-1:0] stat_t;
endpackage

// File: rtl/rdo_rst_sync.sv
module rdo_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/rdo_idle_timer.sv
module rdo_idle_timer #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic kick,
  output logic expire
);
  localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    expire = run && !kick && (cnt_q == LAST);
    cnt_en = 1'b1;
    if (!run || kick || expire) cnt_d = '0;
    else                        cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rdo_stat_reg.sv
module rdo_stat_reg
  import rdo_status_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  stat_t phase_in,
  input  stat_t event_in,
  input  logic  done_in,
  output stat_t stat_word,
  output logic  irq
);
  stat_t phase_q, event_q;
  logic  irq_q;
  logic  irq_d;
  logic  evt_en;

  always_comb begin
    irq_d  = done_in || (|(event_in & EVENT_MASK));
    evt_en = irq_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      event_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      phase_q <= phase_in & PHASE_MASK;
      irq_q   <= irq_d;
      if (evt_en) event_q <= event_in & EVENT_MASK;
    end
  end

  assign stat_word = phase_q | event_q;
  assign irq       = irq_q;
endmodule

// File: rtl/rdo_status_mon.sv
module rdo_status_mon
  import rdo_status_pkg::*;
#(
  parameter int CLK_MHZ    = 200,
  parameter int FIFO_TO_US = 65000,
  parameter int HF_TO_US   = 65000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hdr_wait_i,
  input  logic                fba_valid_i,
  input  logic                frame_rd_i,
  input  logic                fba_wait_i,
  input  logic                eof_err_i,
  input  logic                frame_done_i,
  input  logic                fifo_rd_i,
  input  logic                hf_wait_i,
  input  logic                abort_i,
  output logic [STAT_W-1:0]   stat_word_o,
  output logic                frame_irq_o
);
  localparam int FIFO_LIMIT = CLK_MHZ * FIFO_TO_US;
  localparam int HF_LIMIT   = CLK_MHZ * HF_TO_US;
  localparam int NTMR       = 2;
  localparam int T_FIFO     = 0;
  localparam int T_HF       = 1;

  logic            rst_n_i;
  logic [NTMR-1:0] t_run, t_kick, t_exp;
  stat_t           phase_v, event_v;
  logic            abort_rd;

  rdo_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  always_comb begin
    t_run[T_FIFO]  = frame_rd_i;
    t_kick[T_FIFO] = fifo_rd_i;
    t_run[T_HF]    = hf_wait_i;
    t_kick[T_HF]   = 1'b0;
  end

  for (genvar g = 0; g < NTMR; g++) begin : g_tmr
    localparam int LIM = (g == T_FIFO) ? FIFO_LIMIT : HF_LIMIT;
    rdo_idle_timer #(.LIMIT(LIM)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n_i),
      .run    (t_run[g]),
      .kick   (t_kick[g]),
      .expire (t_exp[g])
    );
  end

  always_comb begin
    abort_rd = abort_i && frame_rd_i;

    phase_v              = '0;
    phase_v[B_HDR_WAIT]  = hdr_wait_i;
    phase_v[B_FBA_VALID] = fba_valid_i;
    phase_v[B_FRAME_RD]  = frame_rd_i;
    phase_v[B_FBA_WAIT]  = fba_wait_i;

    event_v              = '0;
    event_v[B_EOF_ERR]   = eof_err_i;
    event_v[B_LAST]      = t_exp[T_FIFO] || abort_rd;
    event_v[B_ABORT]     = abort_rd;
    event_v[B_FIFO_TO]   = t_exp[T_FIFO];
    event_v[B_HF_TO]     = t_exp[T_HF];
  end

  rdo_stat_reg u_stat (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .phase_in  (phase_v),
    .event_in  (event_v),
    .done_in   (frame_done_i),
    .stat_word (stat_word_o),
    .irq       (frame_irq_o)
  );
endmodule

// File: rtl/rdo_status_mon_chk.sv
module rdo_status_mon_chk
  import rdo_status_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              hdr_wait_i,
  input logic              fba_valid_i,
  input logic              frame_rd_i,
  input logic              fba_wait_i,
  input logic              eof_err_i,
  input logic              frame_done_i,
  input logic              hf_wait_i,
  input logic              abort_i,
  input logic [STAT_W-1:0] stat_word_o,
  input logic              frame_irq_o
);
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_clear_r1: assert (stat_word_o == '0 && !frame_irq_o);
    end
  end

  p_phase_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_word_o & PHASE_MASK) ==
              {1'b0, $past(fba_wait_i), $past(frame_rd_i), 3'b000,
               $past(fba_valid_i), 1'b0, $past(hdr_wait_i)}));

  p_done_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_i |=> frame_irq_o);

  p_eof_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    eof_err_i |=> (frame_irq_o && stat_word_o[B_EOF_ERR]));

  p_tmo_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stat_word_o[B_FIFO_TO] |-> stat_word_o[B_LAST]);

  p_abort_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_i && !frame_rd_i && !eof_err_i && !frame_done_i && !hf_wait_i)
      |=> !frame_irq_o);

  p_evt_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_irq_o |-> $stable(stat_word_o & EVENT_MASK));
endmodule

bind rdo_status_mon rdo_status_mon_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .hdr_wait_i   (hdr_wait_i),
  .fba_valid_i  (fba_valid_i),
  .frame_rd_i   (frame_rd_i),
  .fba_wait_i   (fba_wait_i),
  .eof_err_i    (eof_err_i),
  .frame_done_i (frame_done_i),
  .hf_wait_i    (hf_wait_i),
  .abort_i      (abort_i),
  .stat_word_o  (stat_word_o),
  .frame_irq_o  (frame_irq_o)
);

// File: tb/rdo_status_mon_bench.sv
module rdo_status_mon_bench;
  localparam int MHZ = 1;
  localparam int FTO = 20;
  localparam int HTO = 12;
  localparam int LF  = MHZ * FTO;
  localparam int LH  = MHZ * HTO;

  logic clk = 1'b0;
  logic rst_n;
  logic hdr_wait, fba_valid, frame_rd, fba_wait;
  logic eof_err, frame_done, fifo_rd, hf_wait, abort_p;
  logic [8:0] stat;
  logic irq;

  int checks = 0;
  int fails  = 0;
  int irq_cnt = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rdo_status_mon #(.CLK_MHZ(MHZ), .FIFO_TO_US(FTO), .HF_TO_US(HTO)) u_rdo_status_mon (
    .clk(clk), .rst_n(rst_n),
    .hdr_wait_i(hdr_wait), .fba_valid_i(fba_valid), .frame_rd_i(frame_rd),
    .fba_wait_i(fba_wait), .eof_err_i(eof_err), .frame_done_i(frame_done),
    .fifo_rd_i(fifo_rd), .hf_wait_i(hf_wait), .abort_i(abort_p),
    .stat_word_o(stat), .frame_irq_o(irq)
  );

  always @(posedge clk) begin
    #1;
    if (irq) irq_cnt++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    hdr_wait = 0; fba_valid = 0; frame_rd = 0; fba_wait = 0;
    eof_err = 0; frame_done = 0; fifo_rd = 0; hf_wait = 0; abort_p = 0;
    tick(4);
    chk("R1 status in reset", stat, 0);
    chk("R1 irq in reset", irq, 0);
    rst_n = 1'b1;
    tick(4);
  endtask

  task automatic t_phase;
    hdr_wait = 1; fba_valid = 1;
    tick(1);
    chk("R2 header wait and address valid", stat, 9'h005);
    hdr_wait = 0; fba_valid = 0; fba_wait = 1;
    tick(1);
    chk("R2 address wait", stat, 9'h080);
    fba_wait = 0;
    tick(1);
    chk("R2 phases cleared", stat, 0);
  endtask

  task automatic t_done;
    frame_done = 1; tick(1); frame_done = 0;
    chk("R3 irq on frame done", irq, 1);
    chk("R3 clean word on frame done", stat, 0);
    tick(1);
    chk("R3 irq is one cycle", irq, 0);
  endtask

  task automatic t_eof_hold;
    eof_err = 1; tick(1); eof_err = 0;
    chk("R4 irq on eof error", irq, 1);
    chk("R4 eof bit", stat, 9'h002);
    tick(3);
    chk("R10 eof bit held", stat, 9'h002);
    frame_done = 1; tick(1); frame_done = 0;
    chk("R10 bits recaptured at next irq", stat, 0);
  endtask

  task automatic t_timeout;
    int base;
    base = irq_cnt;
    frame_rd = 1;
    tick(LF - 1);
    chk("R5 no early time-out", irq_cnt, base);
    tick(1);
    chk("R5 irq on time-out", irq, 1);
    chk("R5 time-out word", stat, 9'h068);
    tick(LF - 1);
    chk("R11 no second irq before limit", irq_cnt, base + 1);
    tick(1);
    chk("R11 repeated time-out irq", irq, 1);
    frame_rd = 0;
    tick(2);
  endtask

  task automatic t_kick;
    int base;
    base = irq_cnt;
    frame_rd = 1;
    for (int i = 0; i < 5; i++) begin
      tick(LF - 3);
      fifo_rd = 1; tick(1); fifo_rd = 0;
    end
    chk("R6 strobes prevent time-out", irq_cnt, base);
    frame_rd = 0;
    tick(1);
  endtask

  task automatic t_idle;
    int base;
    base = irq_cnt;
    tick(3 * LF);
    chk("R7 no time-out while idle", irq_cnt, base);
  endtask

  task automatic t_hf;
    hf_wait = 1;
    tick(LH);
    hf_wait = 0;
    chk("R8 irq on half-full time-out", irq, 1);
    chk("R8 half-full word", stat, 9'h100);
    tick(1);
  endtask

  task automatic t_abort;
    int base;
    logic [8:0] snap;
    frame_rd = 1; tick(1);
    abort_p = 1; tick(1); abort_p = 0;
    chk("R9 irq on abort in readout", irq, 1);
    chk("R9 abort word", stat, 9'h058);
    frame_rd = 0; tick(2);
    snap = stat;
    base = irq_cnt;
    abort_p = 1; tick(1); abort_p = 0;
    tick(1);
    chk("R9 idle abort gives no irq", irq_cnt, base);
    chk("R9 idle abort leaves word", stat, snap);
  endtask

  task automatic t_merge;
    int base;
    base = irq_cnt;
    eof_err = 1; frame_done = 1; tick(1);
    eof_err = 0; frame_done = 0;
    chk("R12 merged eof and done word", stat, 9'h002);
    tick(1);
    chk("R12 single irq for coincident events", irq_cnt, base + 1);
    frame_rd = 1; tick(1);
    eof_err = 1; abort_p = 1; tick(1);
    eof_err = 0; abort_p = 0;
    chk("R12 merged eof and abort word", stat, 9'h05A);
    frame_rd = 0; tick(2);
  endtask

  initial begin
    t_reset;
    t_phase;
    t_done;
    t_eof_hold;
    t_timeout;
    t_kick;
    t_idle;
    t_hf;
    t_abort;
    t_merge;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(5 * 20000);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule